// File: doc/BRIEF.md
# Single-Error-Correcting Byte Memory with Correction Flag

This block is a byte-wide memory that keeps four Hamming check bits next to every stored data byte, so each location holds a 12-bit codeword. On every read the codeword is run through a syndrome decoder, and a single flipped bit anywhere in the codeword is repaired in the data presented on the output bus. A separate flag output tells the host whether that read needed a repair. The corrected value is never written back: a damaged location stays damaged and keeps raising the flag until the host writes it again.

The host side behaves like an asynchronous static memory. There are two select inputs (one active low, one active high), a write strobe and an output-drive strobe, plus a bidirectional byte bus that is split into input, output and drive-enable signals. The flag has its own drive enable and follows the same mode decode as the byte bus. Reads are combinational from the address. Writes and resets take effect on the rising clock edge. A test-only port flips one chosen bit of one chosen stored codeword, so that correction can be exercised on purpose.

Top module: `ecc_byte_sram`

## Requirements
- R1: The chip is selected only when `en_lo_n` is 0 and `en_hi` is 1. While it is deselected, `bus_drv` and `fix_drv` are 0 and no location is written, whatever `write_n` and `drive_n` are.
- R2: With the chip selected, `write_n` = 1 and `drive_n` = 0 (read mode), `bus_drv` and `fix_drv` are 1 in the same cycle and `bus_out` shows the byte stored at `addr`.
- R3: With the chip selected and `write_n` = 0 (write mode, either value of `drive_n`), `bus_in` is stored at `addr` on the next rising clock edge, and `bus_drv` and `fix_drv` are 0 during the write.
- R4: With the chip selected, `write_n` = 1 and `drive_n` = 1, both drive enables are 0 and no location is written.
- R5: Codeword positions are numbered 1 to 12. Check bits sit at positions 1, 2, 4 and 8, and data bits d0..d7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12. A single flipped bit at any of the 12 positions is corrected in `bus_out`.
- R6: During a read, `fix_flag` is 1 if a bit was corrected and 0 if the codeword was clean. It is 0 whenever `fix_drv` is 0.
- R7: A correction is never written back to the array. Repeated reads of a damaged location keep returning the corrected byte with `fix_flag` = 1.
- R8: A syndrome of 13, 14 or 15 points outside the codeword. The data bits are then passed through unchanged and `fix_flag` is 0.
- R9: While `rst_n` is 0 at a rising edge, every location is cleared to the all-zero codeword, which reads back as 0x00 with `fix_flag` = 0.
- R10: When `inj_en` is 1 at a rising edge, codeword bit `inj_idx` (value i flips position i+1) at `inj_addr` is inverted. Values 12 to 15 of `inj_idx` have no effect. A write to the same location in the same cycle takes precedence.
- R11: Whenever `bus_drv` is 0, `bus_out` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for writes, injection and reset |
| rst_n | input | 1 | Synchronous active-low reset, clears the array |
| addr | input | AW | Word address for reads and writes |
| en_lo_n | input | 1 | Active-low select |
| en_hi | input | 1 | Active-high select |
| write_n | input | 1 | Active-low write strobe |
| drive_n | input | 1 | Active-low output-drive strobe |
| bus_in | input | 8 | Byte bus, inbound half |
| bus_out | output | 8 | Byte bus, outbound half (corrected data) |
| bus_drv | output | 1 | Drive enable for the byte bus |
| fix_flag | output | 1 | Correction flag value |
| fix_drv | output | 1 | Drive enable for the correction flag |
| inj_en | input | 1 | Test port: flip one stored bit at the next edge |
| inj_addr | input | AW | Test port: location to corrupt |
| inj_idx | input | 4 | Test port: codeword bit index 0 to 11 |

## Verification
The assertions watch the mode decode on every cycle: no drive while deselected, writing or muted, both enables present in read mode, a flag that never rises without its enable, an idle bus held at zero, and unchanged read output while the same address is read with no write or injection in between, which is the visible form of the no-write-back rule. Whether the corrected byte is the right one, which positions are repaired, how a syndrome outside the codeword is handled, and how reset, injection and write precedence act on the stored data can only be shown by the bench. It sweeps every address and every codeword bit position, and it uses chosen double flips to force each out-of-range syndrome.

// File: rtl/ecc_sram_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and position helpers for the corrected byte memory.
// Assumes a 12-bit Hamming layout with check bits at power-of-two positions.
package ecc_sram_pkg;

    localparam int DATA_W = 8;
    localparam int CW_W   = 12;
    localparam int SYN_W  = 4;

    // Access mode produced by the host strobe decode
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_READ  = 2'd1,
        MODE_WRITE = 2'd2,
        MODE_MUTED = 2'd3
    } access_mode_e;

    // 1-based codeword position of data bit i (non-power-of-two slots in order)
    function automatic int data_slot(input int i);
        int res;
        int n;
        res = 0;
        n   = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == i) res = p;
                n = n + 1;
            end
        end
        return res;
    endfunction

    // Mask of codeword bits whose 1-based position has bit k set
    function automatic logic [CW_W-1:0] cover_mask(input int k);
        logic [CW_W-1:0] m;
        m = '0;
        for (int p = 1; p <= CW_W; p++) begin
            if (((p >> k) & 1) == 1) m[p-1] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ecc_mode_decode.sv
`timescale 1ns/1ps
// Decodes the select, write and drive strobes into a single access mode.
// Assumes the strobes are already synchronous to the clock domain of the array.
module ecc_mode_decode
    import ecc_sram_pkg::*;
(
    input  logic en_lo_n,
    input  logic en_hi,
    input  logic write_n,
    input  logic drive_n,
    output logic wr_en,
    output logic rd_en
);

    access_mode_e mode;

    // Select first, then write over read, then drive
    always_comb begin
        if (en_lo_n || !en_hi) begin
            mode = MODE_IDLE;
        end else if (!write_n) begin
            mode = MODE_WRITE;
        end else if (!drive_n) begin
            mode = MODE_READ;
        end else begin
            mode = MODE_MUTED;
        end
    end

    // Mode to one-hot style strobes
    always_comb begin
        wr_en = (mode == MODE_WRITE);
        rd_en = (mode == MODE_READ);
    end

endmodule

// File: rtl/ecc_encoder.sv
`timescale 1ns/1ps
// Builds a 12-bit Hamming codeword from one data byte.
// Check bit k sits at position 2^k and makes the parity of its covered set even.
module ecc_encoder
    import ecc_sram_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CW_W-1:0]   cw
);

    logic [CW_W-1:0]  placed;
    logic [SYN_W-1:0] chk;

    // Data bits into their slots, check slots held at zero
    for (genvar i = 0; i < DATA_W; i++) begin : g_place
        assign placed[data_slot(i)-1] = data[i];
    end
    for (genvar k = 0; k < SYN_W; k++) begin : g_zero
        assign placed[(1 << k)-1] = 1'b0;
    end

    // One parity per check bit over its covered positions
    for (genvar k = 0; k < SYN_W; k++) begin : g_chk
        assign chk[k] = ^(placed & cover_mask(k));
    end

    // Merge check bits into the placed word
    always_comb begin
        cw = placed;
        for (int k = 0; k < SYN_W; k++) begin
            cw[(1 << k)-1] = chk[k];
        end
    end

endmodule

// File: rtl/ecc_decoder.sv
`timescale 1ns/1ps
// Computes the syndrome of a stored codeword and repairs one flipped bit.
// Assumes at most one error for a correct result; an out-of-range syndrome passes data raw.
module ecc_decoder
    import ecc_sram_pkg::*;
(
    input  logic [CW_W-1:0]   cw,
    output logic [DATA_W-1:0] data,
    output logic              fixed
);

    logic [SYN_W-1:0] syn;
    logic [CW_W-1:0]  repaired;

    // Syndrome bit k: parity over positions with bit k set
    for (genvar k = 0; k < SYN_W; k++) begin : g_syn
        assign syn[k] = ^(cw & cover_mask(k));
    end

    // Flip the bit the syndrome names when it lies inside the word
    always_comb begin
        repaired = cw;
        fixed    = 1'b0;
        if ((syn != '0) && (syn <= SYN_W'(CW_W))) begin
            repaired[syn - 1'b1] = ~cw[syn - 1'b1];
            fixed                = 1'b1;
        end
    end

    // Pull the data bits back out of their slots
    for (genvar i = 0; i < DATA_W; i++) begin : g_pick
        assign data[i] = repaired[data_slot(i)-1];
    end

endmodule

// File: rtl/ecc_code_store.sv
`timescale 1ns/1ps
// Codeword array with a combinational read port, a clocked write port and a
// test-only single-bit flip port. DEPTH is assumed to be a power of two.
module ecc_code_store
    import ecc_sram_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [CW_W-1:0]   wr_cw,
    input  logic              inj_en,
    input  logic [AW-1:0]     inj_addr,
    input  logic [SYN_W-1:0]  inj_idx,
    input  logic [AW-1:0]     rd_addr,
    output logic [CW_W-1:0]   rd_cw
);

    logic [CW_W-1:0] mem [DEPTH];

    // Reset clear, then bit flip, then write (write assignment comes last and wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (inj_en && (inj_idx < SYN_W'(CW_W))) begin
                mem[inj_addr][inj_idx] <= ~mem[inj_addr][inj_idx];
            end
            if (wr_en) begin
                mem[wr_addr] <= wr_cw;
            end
        end
    end

    // Asynchronous read of the addressed codeword
    always_comb begin
        rd_cw = mem[rd_addr];
    end

endmodule

// File: rtl/ecc_byte_sram.sv
`timescale 1ns/1ps
// Byte memory with per-byte Hamming protection, on-the-fly single-bit repair
// and a correction flag. Reads are combinational; writes are clocked.
// Repaired data is never written back to the array.
module ecc_byte_sram
    import ecc_sram_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              en_lo_n,
    input  logic              en_hi,
    input  logic              write_n,
    input  logic              drive_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_drv,
    output logic              fix_flag,
    output logic              fix_drv,
    input  logic              inj_en,
    input  logic [AW-1:0]     inj_addr,
    input  logic [SYN_W-1:0]  inj_idx
);

    logic              wr_en;
    logic              rd_en;
    logic [CW_W-1:0]   enc_cw;
    logic [CW_W-1:0]   rd_cw;
    logic [DATA_W-1:0] dec_data;
    logic              dec_fixed;

    ecc_mode_decode u_mode (
        .en_lo_n (en_lo_n),
        .en_hi   (en_hi),
        .write_n (write_n),
        .drive_n (drive_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en)
    );

    ecc_encoder u_enc (
        .data (bus_in),
        .cw   (enc_cw)
    );

    ecc_code_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (addr),
        .wr_cw    (enc_cw),
        .inj_en   (inj_en),
        .inj_addr (inj_addr),
        .inj_idx  (inj_idx),
        .rd_addr  (addr),
        .rd_cw    (rd_cw)
    );

    ecc_decoder u_dec (
        .cw    (rd_cw),
        .data  (dec_data),
        .fixed (dec_fixed)
    );

    // Output stage: drive only in read mode, hold zero otherwise
    always_comb begin
        bus_drv  = rd_en;
        fix_drv  = rd_en;
        bus_out  = rd_en ? dec_data : '0;
        fix_flag = rd_en & dec_fixed;
    end

endmodule

// File: rtl/ecc_byte_sram_chk.sv
`timescale 1ns/1ps
// Cycle-level checks on the host pins of the corrected byte memory.
// Attached to every instance of the top module by the bind at the end of this file.
module ecc_byte_sram_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          en_lo_n,
    input logic          en_hi,
    input logic          write_n,
    input logic          drive_n,
    input logic [7:0]    bus_out,
    input logic          bus_drv,
    input logic          fix_flag,
    input logic          fix_drv,
    input logic          inj_en
);

    logic past_ok;
    logic sel;
    logic rd_now;

    // Marks that the previous edge was a non-reset edge
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Pin-level view of the mode decode
    always_comb begin
        sel    = !en_lo_n && en_hi;
        rd_now = sel && write_n && !drive_n;
    end

    assert_deselect_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (!bus_drv && !fix_drv));

    assert_read_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_now |-> (bus_drv && fix_drv));

    assert_write_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !write_n) |-> (!bus_drv && !fix_drv));

    assert_muted_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && write_n && drive_n) |-> (!bus_drv && !fix_drv));

    assert_flag_needs_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fix_flag |-> fix_drv);

    assert_no_writeback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rd_now && $past(rd_now) && (addr == $past(addr)) && !$past(inj_en))
        |-> ($stable(bus_out) && $stable(fix_flag)));

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_drv |-> (bus_out == 8'h00));

endmodule

bind ecc_byte_sram ecc_byte_sram_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_ecc_byte_sram.sv
`timescale 1ns/1ps
// Sweep bench: every address, every codeword bit, the mode table and the
// out-of-range syndromes, with expected bytes computed here.
module sim_ecc_byte_sram;

    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          en_lo_n, en_hi, write_n, drive_n;
    logic [7:0]    bus_in;
    logic [7:0]    bus_out;
    logic          bus_drv, fix_flag, fix_drv;
    logic          inj_en;
    logic [AW-1:0] inj_addr;
    logic [3:0]    inj_idx;

    int  vectors = 0;
    int  misses  = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    ecc_byte_sram #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .en_lo_n(en_lo_n), .en_hi(en_hi), .write_n(write_n), .drive_n(drive_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_drv(bus_drv),
        .fix_flag(fix_flag), .fix_drv(fix_drv),
        .inj_en(inj_en), .inj_addr(inj_addr), .inj_idx(inj_idx)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 8'hff);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        en_lo_n = 1'b1; en_hi = 1'b0; write_n = 1'b1; drive_n = 1'b1;
        inj_en = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [7:0] d, input logic oe_n);
        @(negedge clk);
        addr = AW'(a); bus_in = d;
        en_lo_n = 1'b0; en_hi = 1'b1; write_n = 1'b0; drive_n = oe_n;
        #1;
        chk(!bus_drv && !fix_drv, "R3", "drive during write", {bus_drv, fix_drv}, 0);
        @(negedge clk);
        idle();
    endtask

    task automatic read_chk(input int a, input logic [7:0] exp_d, input logic exp_f,
                            input string req);
        @(negedge clk);
        addr = AW'(a);
        en_lo_n = 1'b0; en_hi = 1'b1; write_n = 1'b1; drive_n = 1'b0;
        #1;
        chk(bus_drv && fix_drv, "R2", "drive in read", {bus_drv, fix_drv}, 3);
        chk(bus_out == exp_d, req, "read data", bus_out, exp_d);
        chk(fix_flag == exp_f, req, "flag", fix_flag, exp_f);
    endtask

    task automatic flip(input int a, input int idx);
        @(negedge clk);
        inj_en = 1'b1; inj_addr = AW'(a); inj_idx = 4'(idx);
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    // Walk all strobe combinations across a clock edge with bus_in = FF
    task automatic strobe_sweep();
        logic [3:0] v;
        for (int c = 0; c < 16; c++) begin
            v = c[3:0];
            if (!(v[3] == 1'b0 && v[2] == 1'b1)) begin
                @(negedge clk);
                addr = 4'd3; bus_in = 8'hFF;
                en_lo_n = v[3]; en_hi = v[2]; write_n = v[1]; drive_n = v[0];
                #1;
                chk(!bus_drv && !fix_drv, "R1", "drive while deselected", {bus_drv, fix_drv}, 0);
                chk(bus_out == 8'h00 && !fix_flag, "R11", "idle outputs", bus_out, 0);
            end
        end
        @(negedge clk);
        en_lo_n = 1'b0; en_hi = 1'b1; write_n = 1'b1; drive_n = 1'b1;
        #1;
        chk(!bus_drv && !fix_drv, "R4", "drive while muted", {bus_drv, fix_drv}, 0);
        chk(bus_out == 8'h00, "R11", "muted bus", bus_out, 0);
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 1'b0; addr = '0; bus_in = '0; inj_addr = '0; inj_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: every location reads zero and clean after reset
        for (int a = 0; a < DEPTH; a++) read_chk(a, 8'h00, 1'b0, "R9");

        // R2/R3: fill with a pattern, half with drive_n low during the write
        for (int a = 0; a < DEPTH; a++) do_write(a, pat(a), a[0]);
        for (int a = 0; a < DEPTH; a++) read_chk(a, pat(a), 1'b0, "R3");

        // R1/R4/R11: no strobe mix outside write mode touches location 3
        strobe_sweep();
        read_chk(3, pat(3), 1'b0, "R1");

        // R5/R6/R7/R10: every bit of every location, read twice
        for (int a = 0; a < DEPTH; a++) begin
            for (int b = 0; b < 12; b++) begin
                do_write(a, pat(a + b), 1'b1);
                flip(a, b);
                read_chk(a, pat(a + b), 1'b1, "R5");
                read_chk(a, pat(a + b), 1'b1, "R7");
            end
        end

        // R6: rewrite clears the damage
        do_write(2, 8'hA5, 1'b1);
        read_chk(2, 8'hA5, 1'b0, "R6");

        // R8: positions 1+12 -> syndrome 13, d7 stays flipped
        do_write(4, 8'h6B, 1'b1);
        flip(4, 0); flip(4, 11);
        read_chk(4, 8'h6B ^ 8'h80, 1'b0, "R8");
        // R8: positions 5+8 -> syndrome 13, d1 stays flipped
        do_write(5, 8'h11, 1'b1);
        flip(5, 4); flip(5, 7);
        read_chk(5, 8'h11 ^ 8'h02, 1'b0, "R8");
        // R8: positions 3+12 -> syndrome 15, d0 and d7 stay flipped
        do_write(6, 8'hC3, 1'b1);
        flip(6, 2); flip(6, 11);
        read_chk(6, 8'hC3 ^ 8'h81, 1'b0, "R8");
        // R8: positions 6+8 -> syndrome 14, d2 stays flipped
        do_write(8, 8'h00, 1'b1);
        flip(8, 5); flip(8, 7);
        read_chk(8, 8'h04, 1'b0, "R8");

        // R10: out-of-range index leaves the word alone
        do_write(7, 8'h3C, 1'b1);
        for (int i = 12; i < 16; i++) flip(7, i);
        read_chk(7, 8'h3C, 1'b0, "R10");

        // R10: write and flip on the same location in one cycle, write wins
        @(negedge clk);
        addr = 4'd9; bus_in = 8'h99;
        en_lo_n = 1'b0; en_hi = 1'b1; write_n = 1'b0; drive_n = 1'b1;
        inj_en = 1'b1; inj_addr = 4'd9; inj_idx = 4'd2;
        @(negedge clk);
        idle();
        read_chk(9, 8'h99, 1'b0, "R10");

        // R9: a second reset clears damaged and written words alike
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_chk(4, 8'h00, 1'b0, "R9");
        read_chk(9, 8'h00, 1'b0, "R9");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule